// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block drives the request and terminal-count pins that a peripheral presents to a host DMA engine. A one-clock start pulse captures the configuration from plain input ports: a transfer mode, a transfer total, a burst-length value and the active level of each output pin. The block then raises its request and counts every acknowledged transfer. On the last one it pulses terminal count and goes quiet until the next start.

There are four modes. Single-transfer mode drops the request for one clock after each transfer. Burst mode holds the request for the whole transfer. The two limited-burst modes cut each continuous burst short. One limits the burst by a count of 100 ns ticks, taken from a tick-enable input. The other limits it by a count of acknowledged transfers. After the cut the request drops for one clock, and a new burst starts while transfers remain. In every length field, an all-zero value stands for the field's largest value.

Top module: `dma_req_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) restores mode 00 and both polarity bits to 0, clears all counters, and returns `dreq`, `tc` and `cyc_err` to 0 from the next clock.
- R2: In mode 00 (single), an accepted transfer that is not the last one negates the request in the next clock for exactly one clock. The request is then asserted again.
- R3: In mode 01 (burst), the request stays asserted without a break until the last transfer is accepted.
- R4: In mode 10 (tick-limited), each burst ends after `burst_len` clocks with `tick_100ns` high inside the burst (0 means 256). The request is then negated for one clock and asserted again.
- R5: In mode 11 (count-limited), each burst ends after `burst_len` accepted transfers (0 means 256). The request is then negated for one clock and asserted again.
- R6: `tc` is active only in the clock where the last transfer is accepted (`ack` high while the request is asserted). From the next clock, the request stays negated until a new start.
- R7: The number of accepted transfers per start equals `xfer_count`, with 0 meaning 512. This holds in every mode.
- R8: In mode 11, a `burst_len` of 1 acts as 2. `cyc_err` is high from the clock after such a start until the next start or reset. Otherwise `cyc_err` is 0.
- R9: Polarity bits are captured at start. Each pin equals its internal active level when its bit is 0 and the inverse when it is 1; bit 1 means active low.
- R10: A start pulse, or any change to the configuration inputs, while a transfer is in progress has no effect on that transfer.
- R11: An `ack` while the request is negated is not counted.
- R12: The request is asserted in the clock after a start pulse accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock pulse that captures the configuration and begins a transfer |
| mode_sel | input | 2 | 00 single, 01 burst, 10 tick-limited burst, 11 count-limited burst |
| tc_active_low | input | 1 | 1 makes `tc` active low |
| req_active_low | input | 1 | 1 makes `dreq` active low |
| xfer_count | input | TC_W | Transfer total, 0 means 2^TC_W |
| burst_len | input | BL_W | Burst limit in ticks or transfers, 0 means 2^BL_W |
| tick_100ns | input | 1 | Tick enable, one clock every 100 ns |
| ack | input | 1 | Transfer acknowledge from the DMA engine |
| dreq | output | 1 | DMA request pin |
| tc | output | 1 | Terminal-count pin |
| cyc_err | output | 1 | Illegal count-limited burst length was programmed |

## Verification
The bench targets the zero encodings: a 512-transfer burst and 256-tick and 256-transfer burst limits. A design that read zero literally would stop at once or never cut the burst. It drives random `ack` that lands in gaps and in the same clock as a burst expiry. A design that counted gap acknowledges, or that let expiry override the final transfer, would end early or leave the request raised after `tc`. A mid-transfer restart with a changed count catches a design that reloads its counters. Active-low runs and a burst length of 1 catch inverted idle levels and a missing substitute limit.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_GAP  = 2'd2
   } dreq_state_t;

   typedef enum logic [1:0] {
      MD_SINGLE = 2'd0,
      MD_BURST  = 2'd1,
      MD_TIMED  = 2'd2,
      MD_CYCLED = 2'd3
   } xfer_mode_t;

   typedef struct packed {
      xfer_mode_t mode;
      logic       tc_low;
      logic       req_low;
   } dreq_cfg_t;

   localparam dreq_cfg_t CFG_DEFAULT = '{mode: MD_SINGLE, tc_low: 1'b0, req_low: 1'b0};

endpackage

// File: rtl/dreq_xfer_counter.sv
module dreq_xfer_counter #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last,
   output logic [CNT_W:0]   remaining
);
   localparam int RW = CNT_W + 1;
   localparam logic [RW-1:0] FULL = RW'(1) << CNT_W;

   logic [RW-1:0] rem_q;

   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_width
      $error("dreq_xfer_counter: CNT_W out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= (load_val == '0) ? FULL : {1'b0, load_val};
      end else if (dec && rem_q != '0) begin
         rem_q <= rem_q - RW'(1);
      end
   end

   assign last      = (rem_q == RW'(1));
   assign remaining = rem_q;

endmodule

// File: rtl/dreq_burst_limiter.sv
module dreq_burst_limiter
   import dreq_pkg::*;
#(
   parameter int LEN_W   = 8,
   parameter int MIN_CYC = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  xfer_mode_t       mode,
   input  logic [LEN_W-1:0] len,
   input  logic             tick,
   input  logic             ack,
   output logic             expire,
   output logic             len_bad
);
   localparam int RW = LEN_W + 1;
   localparam logic [RW-1:0] MAX_LIM = RW'(1) << LEN_W;
   localparam logic [RW-1:0] MIN_LIM = RW'(MIN_CYC);

   logic [RW-1:0] limit;
   logic [RW-1:0] cnt_q;
   logic          step;

   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_width
      $error("dreq_burst_limiter: LEN_W out of range");
   end
   if (MIN_CYC < 1 || MIN_CYC >= (1 << LEN_W)) begin : g_bad_min
      $error("dreq_burst_limiter: MIN_CYC out of range");
   end

   always_comb begin
      len_bad = (mode == MD_CYCLED) && (len != '0) && ({1'b0, len} < MIN_LIM);
      if (len == '0) begin
         limit = MAX_LIM;
      end else if (len_bad) begin
         limit = MIN_LIM;
      end else begin
         limit = {1'b0, len};
      end
      case (mode)
         MD_TIMED:  step = run && tick;
         MD_CYCLED: step = run && ack;
         default:   step = 1'b0;
      endcase
      expire = step && (cnt_q == limit - RW'(1));
   end

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + RW'(1);
      end
   end

endmodule

// File: rtl/dreq_pin_pol.sv
module dreq_pin_pol #(
   parameter int N = 2
) (
   input  logic [N-1:0] active,
   input  logic [N-1:0] low,
   output logic [N-1:0] pin
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      assign pin[i] = low[i] ? ~active[i] : active[i];
   end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
   import dreq_pkg::*;
#(
   parameter int TC_W = 9,
   parameter int BL_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [1:0]      mode_sel,
   input  logic            tc_active_low,
   input  logic            req_active_low,
   input  logic [TC_W-1:0] xfer_count,
   input  logic [BL_W-1:0] burst_len,
   input  logic            tick_100ns,
   input  logic            ack,
   output logic            dreq,
   output logic            tc,
   output logic            cyc_err
);
   localparam int PINS = 2;

   dreq_state_t     state_q, state_d;
   dreq_cfg_t       cfg_q;
   logic [BL_W-1:0] len_q;
   logic            in_req, accept, last, final_xfer, expire, take_start;
   logic [TC_W:0]   remaining;
   logic [PINS-1:0] pin_act, pin_low, pin_out;

   if (TC_W < 2) begin : g_bad_tc
      $error("dma_req_ctrl: TC_W must be at least 2");
   end
   if (BL_W < 2) begin : g_bad_bl
      $error("dma_req_ctrl: BL_W must be at least 2");
   end

   assign in_req     = (state_q == ST_REQ);
   assign accept     = in_req && ack;
   assign take_start = (state_q == ST_IDLE) && start;
   assign final_xfer = accept && last;

   dreq_xfer_counter #(.CNT_W(TC_W)) u_count (
      .clk       (clk),
      .rst       (rst),
      .load      (take_start),
      .load_val  (xfer_count),
      .dec       (accept),
      .last      (last),
      .remaining (remaining)
   );

   dreq_burst_limiter #(.LEN_W(BL_W), .MIN_CYC(2)) u_limit (
      .clk     (clk),
      .rst     (rst),
      .run     (in_req),
      .mode    (cfg_q.mode),
      .len     (len_q),
      .tick    (tick_100ns),
      .ack     (accept),
      .expire  (expire),
      .len_bad (cyc_err)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start) state_d = ST_REQ;
         ST_REQ: begin
            if (final_xfer) begin
               state_d = ST_IDLE;
            end else if (accept && cfg_q.mode == MD_SINGLE) begin
               state_d = ST_GAP;
            end else if (expire) begin
               state_d = ST_GAP;
            end
         end
         ST_GAP:  state_d = ST_REQ;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cfg_q   <= CFG_DEFAULT;
         len_q   <= '0;
      end else begin
         state_q <= state_d;
         if (take_start) begin
            cfg_q.mode    <= xfer_mode_t'(mode_sel);
            cfg_q.tc_low  <= tc_active_low;
            cfg_q.req_low <= req_active_low;
            len_q         <= burst_len;
         end
      end
   end

   assign pin_act = {final_xfer, in_req};
   assign pin_low = {cfg_q.tc_low, cfg_q.req_low};

   dreq_pin_pol #(.N(PINS)) u_pol (
      .active (pin_act),
      .low    (pin_low),
      .pin    (pin_out)
   );

   assign tc   = pin_out[1];
   assign dreq = pin_out[0];

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk
   import dreq_pkg::*;
#(
   parameter int TC_W = 9,
   parameter int BL_W = 8
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            ack,
   input logic            tick_100ns,
   input logic            dreq,
   input logic            tc,
   input logic            cyc_err,
   input dreq_state_t     state_q,
   input dreq_cfg_t       cfg_q,
   input logic [BL_W-1:0] len_q,
   input logic [TC_W:0]   remaining
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (dreq == 1'b0 && tc == 1'b0 && cyc_err == 1'b0));

   assert_single_gap_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_GAP && cfg_q.mode == MD_SINGLE) |=> (state_q == ST_REQ));

   assert_burst_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_REQ && cfg_q.mode == MD_BURST && tc == cfg_q.tc_low)
      |=> (state_q == ST_REQ));

   assert_timed_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_REQ && cfg_q.mode == MD_TIMED && !ack && !tick_100ns)
      |=> (state_q == ST_REQ));

   assert_cycled_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_REQ && cfg_q.mode == MD_CYCLED && !ack) |=> (state_q == ST_REQ));

   assert_tc_ends_R6: assert property (@(posedge clk) disable iff (rst)
      (tc != cfg_q.tc_low) |=> (state_q == ST_IDLE && dreq == cfg_q.req_low));

   assert_err_on_start_R8: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_IDLE) |=> $stable(cyc_err));

   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_IDLE) |=> ($stable(cfg_q) && $stable(len_q)));

   assert_gap_no_count_R11: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_GAP) |=> $stable(remaining));

   assert_start_req_R12: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && start) |=> (dreq != cfg_q.req_low));

endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(.TC_W(TC_W), .BL_W(BL_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .ack        (ack),
   .tick_100ns (tick_100ns),
   .dreq       (dreq),
   .tc         (tc),
   .cyc_err    (cyc_err),
   .state_q    (state_q),
   .cfg_q      (cfg_q),
   .len_q      (len_q),
   .remaining  (remaining)
);

// File: tb/dma_req_ctrl_test.sv
module dma_req_ctrl_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic       tc_active_low = 1'b0;
   logic       req_active_low = 1'b0;
   logic [8:0] xfer_count = 9'd0;
   logic [7:0] burst_len = 8'd0;
   logic       tick_100ns = 1'b0;
   logic       ack = 1'b0;
   logic       dreq, tc, cyc_err;

   int checks = 0;
   int errors = 0;
   int tick_div = 0;

   // behavioural reference state
   int m_st = 0;      // 0 idle, 1 requesting, 2 gap
   int m_mode = 0;
   int m_tp = 0;
   int m_rp = 0;
   int m_err = 0;
   int m_rem = 0;
   int m_lim = 0;
   int m_bc = 0;

   always #4 clk = ~clk;

   dma_req_ctrl uut (
      .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
      .tc_active_low(tc_active_low), .req_active_low(req_active_low),
      .xfer_count(xfer_count), .burst_len(burst_len),
      .tick_100ns(tick_100ns), .ack(ack),
      .dreq(dreq), .tc(tc), .cyc_err(cyc_err)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_mode = 0; m_tp = 0; m_rp = 0; m_err = 0; m_rem = 0; m_bc = 0;
      end else if (m_st == 0) begin
         if (start) begin
            m_mode = int'(mode_sel);
            m_tp   = int'(tc_active_low);
            m_rp   = int'(req_active_low);
            m_rem  = (xfer_count == 0) ? 512 : int'(xfer_count);
            m_lim  = (burst_len == 0) ? 256 : int'(burst_len);
            m_err  = (m_mode == 3 && burst_len == 1) ? 1 : 0;
            if (m_err == 1) m_lim = 2;
            m_bc = 0;
            m_st = 1;
         end
      end else if (m_st == 2) begin
         m_bc = 0;
         m_st = 1;
      end else begin
         if (ack && m_rem == 1) begin
            m_rem = 0;
            m_st = 0;
         end else begin
            if (ack) m_rem = m_rem - 1;
            if (ack && m_mode == 0) m_st = 2;
            if ((m_mode == 2 && tick_100ns) || (m_mode == 3 && ack)) begin
               m_bc = m_bc + 1;
               if (m_bc == m_lim) m_st = 2;
            end
         end
      end
   end

   always @(negedge clk) begin
      tick_100ns <= (tick_div > 0) ? (($urandom % tick_div) == 0) : 1'b0;
   end

   function automatic string mode_tag(int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   // per-clock comparison against the reference
   always @(negedge clk) begin
      logic e_dreq, e_tc, e_err;
      #2;
      if (!rst) begin
         e_dreq = ((m_st == 1) ? 1'b1 : 1'b0) ^ m_rp[0];
         e_tc   = ((m_st == 1 && ack && m_rem == 1) ? 1'b1 : 1'b0) ^ m_tp[0];
         e_err  = m_err[0];
         checks += 3;
         if (dreq !== e_dreq) begin
            errors++;
            $display("FAIL %s/R9 dreq actual=%b expected=%b t=%0t", mode_tag(m_mode), dreq, e_dreq, $time);
         end
         if (tc !== e_tc) begin
            errors++;
            $display("FAIL R6 tc actual=%b expected=%b t=%0t", tc, e_tc, $time);
         end
         if (cyc_err !== e_err) begin
            errors++;
            $display("FAIL R8 cyc_err actual=%b expected=%b t=%0t", cyc_err, e_err, $time);
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_xfer(input int m, input int t, input int b, input int tp, input int rp,
                           input int pct, input int tdiv, input bit restart_mid);
      int accepted = 0;
      int n = 0;
      int want;
      bit done = 0;
      want = (t == 0) ? 512 : t;
      tick_div = tdiv;
      @(negedge clk);
      mode_sel = 2'(m); xfer_count = 9'(t); burst_len = 8'(b);
      tc_active_low = tp[0]; req_active_low = rp[0];
      start = 1'b1; ack = 1'b0;
      @(negedge clk);
      start = 1'b0;
      #3;
      check("R12 request after start", int'(dreq), 1 - rp);
      while (!done && n < 20000) begin
         @(negedge clk);
         ack = (($urandom % 100) < pct);
         start = (restart_mid && n == 10);
         if (restart_mid && n == 10) begin
            xfer_count = 9'd3; mode_sel = 2'd1; req_active_low = ~req_active_low;
         end
         #1;
         if (ack && m_st == 1) begin
            accepted++;
            if (m_rem == 1) done = 1;
         end
         n++;
      end
      @(negedge clk);
      ack = 1'b1; start = 1'b0;
      check(restart_mid ? "R10 total unchanged by restart" : "R7/R11 accepted total", accepted, want);
      repeat (3) @(negedge clk);
      #3;
      check("R6 request stays negated", int'(dreq), rp);
      check("R9 idle tc level", int'(tc), tp);
      ack = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #3;
      check("R1 reset dreq", int'(dreq), 0);
      check("R1 reset tc", int'(tc), 0);
      check("R1 reset cyc_err", int'(cyc_err), 0);
      // single mode, ack also held through gaps (R11)
      run_xfer(0, 5, 0, 0, 0, 100, 0, 0);
      run_xfer(0, 17, 0, 1, 0, 60, 0, 0);
      // burst mode, zero count means 512
      run_xfer(1, 0, 0, 0, 0, 100, 0, 0);
      run_xfer(1, 1, 0, 0, 1, 50, 0, 0);
      // tick-limited bursts
      run_xfer(2, 40, 3, 0, 0, 50, 2, 0);
      run_xfer(2, 0, 0, 0, 0, 50, 1, 0);
      // count-limited bursts, illegal length 1 then zero
      run_xfer(3, 20, 1, 0, 0, 70, 0, 0);
      check("R8 error flag held while idle", int'(cyc_err), 1);
      run_xfer(3, 300, 0, 0, 0, 50, 0, 0);
      check("R8 error flag cleared by new start", int'(cyc_err), 0);
      // active-low pins with a restart attempt mid transfer
      run_xfer(3, 30, 5, 1, 1, 80, 0, 1);
      // reset in the middle of a transfer
      @(negedge clk);
      mode_sel = 2'd3; burst_len = 8'd1; xfer_count = 9'd50;
      tc_active_low = 1'b1; req_active_low = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; ack = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; ack = 1'b0;
      #3;
      check("R1 dreq after reset", int'(dreq), 0);
      check("R1 tc after reset", int'(tc), 0);
      check("R1 cyc_err after reset", int'(cyc_err), 0);
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule